// File: doc/BRIEF.md
# Nested-Task Return Link Validator

This block runs the link-following half of an interrupt return made while the nested-task flag is set. On a start pulse it reads the back-link selector stored at the bottom of the current task state segment, uses that selector to fetch an 8-byte descriptor from the global table, and validates the descriptor. A descriptor that passes is handed to the task-switch engine as a request carrying the selector and all 64 descriptor bits. Once the engine reports completion, the block checks the new instruction pointer against the new code-segment limit.

Every operation ends in exactly one of three outcomes, each marked by a single-cycle done pulse: clean completion, an architectural fault (vector number plus 16-bit error code), or an internal-error flag. All memory traffic uses a request/acknowledge read port that returns 32-bit words. The task switch itself and paging live outside the block.

Top module: `nt_return_link_chk`

## Requirements
- R1: After a valid start, the block makes one read at `tr_base_i` and takes bits 15:0 of the returned word as the link selector, ignoring bits 31:16. Each read holds `mem_req_o` high and `mem_addr_o` stable until the cycle in which `mem_ack_i` is sampled high.
- R2: When selector bit 2 (table indicator) is 1, the block raises vector 10 with error code equal to the selector with bits 1:0 cleared. No further reads follow.
- R3: When `{selector[15:3],3'b111}` exceeds `gdt_limit_i`, the block raises vector 10 with the masked selector and stops after the link read. A last byte equal to the limit is accepted.
- R4: The descriptor is read as a low word at `gdt_base_i + 8*selector[15:3]`, then a high word at that address plus 4. When bit 12 of the high word is set (a code or data segment), the block raises vector 10 with the masked selector.
- R5: The type field, bits 11:8 of the high word, must be 11 (busy 32-bit task segment) or 3 (busy 16-bit task segment). Any other value raises vector 10 with the masked selector.
- R6: When bit 15 of the high word (present) is clear, the block raises vector 11 with the masked selector. This applies only when the type checks pass; a descriptor that fails both reports vector 10.
- R7: A descriptor that passes holds `switch_req_o` high, with `switch_sel_o` equal to the selector and `switch_desc_o` equal to {high word, low word}, until `switch_done_i` is sampled high.
- R8: In the cycle `switch_done_i` is sampled, `new_eip_i` greater than `new_cs_limit_i` raises vector 13 with error code 0. Equality completes without a fault.
- R9: An invalid task register (`tr_valid_i` low) or a set `v86_i` ends the operation with `int_err_o` high, no fault and no memory read.
- R10: With `long_mode_i` high, the block raises vector 13 with error code 0 and makes no read. This check takes priority over the R9 checks.
- R11: Each operation gives exactly one outcome and one single-cycle `done_o` pulse. The outcome outputs hold until the next accepted start. A start seen while an operation is in flight is ignored.
- R12: During reset and right after it, `done_o`, `fault_o`, `int_err_o`, `mem_req_o` and `switch_req_o` are low. A reset in mid-operation abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| long_mode_i | input | 1 | Processor is in 64-bit long mode |
| v86_i | input | 1 | Virtual-8086 flag |
| tr_valid_i | input | 1 | Task register cache valid |
| tr_base_i | input | ADDR_W | Base of current task state segment |
| gdt_base_i | input | ADDR_W | Global descriptor table base |
| gdt_limit_i | input | 16 | Global descriptor table limit |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Read address |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| switch_req_o | output | 1 | Task switch request |
| switch_sel_o | output | 16 | Selector for the task switch |
| switch_desc_o | output | 64 | Descriptor for the task switch |
| switch_done_i | input | 1 | Task switch finished |
| new_eip_i | input | EIP_W | Instruction pointer after the switch |
| new_cs_limit_i | input | EIP_W | Scaled code-segment limit after the switch |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Outcome is a fault |
| fault_vec_o | output | 8 | Fault vector number |
| fault_err_o | output | 16 | Fault error code |
| int_err_o | output | 1 | Outcome is an internal error |

## Verification
The assertions assume `mem_ack_i` rises only while `mem_req_o` is high and `switch_done_i` rises only while `switch_req_o` is high. Under those assumptions, hold-until-acknowledge and the single-pulse done are meaningful. The bench's memory and task-switch models answer exactly one cycle after seeing a request, then drop their response, so neither answer can appear unprompted. Requests land only on the addresses of the link word and the two descriptor words; any other address returns a poison pattern that would show up as a wrong selector or descriptor.

// File: rtl/nt_pkg.sv
`timescale 1ns/1ps
package nt_pkg;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] VEC_TS = 8'd10;
  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_GP = 8'd13;

  localparam logic [3:0] TYPE_BUSY32 = 4'd11;
  localparam logic [3:0] TYPE_BUSY16 = 4'd3;

  // descriptor high-word fields
  localparam int unsigned HI_S_BIT = 12;
  localparam int unsigned HI_P_BIT = 15;
  localparam int unsigned HI_TYPE_LSB = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LINK, ST_DLO, ST_DHI, ST_SWITCH
  } nt_state_e;

  typedef struct packed {
    logic            hit;
    logic [7:0]      vec;
    logic [SEL_W-1:0] err;
  } nt_fault_t;
endpackage

// File: rtl/nt_link_check.sv
`timescale 1ns/1ps
module nt_link_check
  import nt_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  input  logic [SEL_W-1:0] tbl_limit_i,
  output nt_fault_t        flt_o
);
  logic [SEL_W-1:0] last_byte;
  logic             local_tbl;

  assign last_byte = {sel_i[SEL_W-1:3], 3'b111};
  assign local_tbl = sel_i[2];

  always_comb begin
    flt_o     = '0;
    flt_o.vec = VEC_TS;
    flt_o.err = {sel_i[SEL_W-1:2], 2'b00};
    flt_o.hit = local_tbl || (last_byte > tbl_limit_i);
  end
endmodule

// File: rtl/nt_desc_check.sv
`timescale 1ns/1ps
module nt_desc_check
  import nt_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] hi_i,
  output nt_fault_t         flt_o
);
  logic [3:0] dtype;
  logic       bad_kind, bad_type, absent;

  assign dtype    = hi_i[HI_TYPE_LSB +: 4];
  assign bad_kind = hi_i[HI_S_BIT];
  assign bad_type = (dtype != TYPE_BUSY32) && (dtype != TYPE_BUSY16);
  assign absent   = !hi_i[HI_P_BIT];

  always_comb begin
    flt_o     = '0;
    flt_o.err = {sel_i[SEL_W-1:2], 2'b00};
    // type checks outrank presence
    if (bad_kind || bad_type) begin
      flt_o.hit = 1'b1;
      flt_o.vec = VEC_TS;
    end else if (absent) begin
      flt_o.hit = 1'b1;
      flt_o.vec = VEC_NP;
    end
  end
endmodule

// File: rtl/nt_eip_check.sv
`timescale 1ns/1ps
module nt_eip_check
  import nt_pkg::*;
#(
  parameter int unsigned EIP_W = 32
) (
  input  logic [EIP_W-1:0] eip_i,
  input  logic [EIP_W-1:0] limit_i,
  output nt_fault_t        flt_o
);
  always_comb begin
    flt_o     = '0;
    flt_o.vec = VEC_GP;
    flt_o.hit = eip_i > limit_i;
  end
endmodule

// File: rtl/nt_return_link_chk.sv
`timescale 1ns/1ps
module nt_return_link_chk
  import nt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EIP_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                long_mode_i,
  input  logic                v86_i,
  input  logic                tr_valid_i,
  input  logic [ADDR_W-1:0]   tr_base_i,
  input  logic [ADDR_W-1:0]   gdt_base_i,
  input  logic [15:0]         gdt_limit_i,
  output logic                mem_req_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  input  logic                mem_ack_i,
  input  logic [31:0]         mem_rdata_i,
  output logic                switch_req_o,
  output logic [15:0]         switch_sel_o,
  output logic [63:0]         switch_desc_o,
  input  logic                switch_done_i,
  input  logic [EIP_W-1:0]    new_eip_i,
  input  logic [EIP_W-1:0]    new_cs_limit_i,
  output logic                done_o,
  output logic                fault_o,
  output logic [7:0]          fault_vec_o,
  output logic [15:0]         fault_err_o,
  output logic                int_err_o
);
  localparam int unsigned PAD_W = ADDR_W - SEL_W;

  nt_state_e         state_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] dlo_q, dhi_q;
  logic              done_q, int_err_q;
  nt_fault_t         fault_q;
  nt_fault_t         link_flt, desc_flt, eip_flt, gp_flt;
  logic [ADDR_W-1:0] desc_addr;

  nt_link_check u_link (
    .sel_i       (mem_rdata_i[SEL_W-1:0]),
    .tbl_limit_i (gdt_limit_i),
    .flt_o       (link_flt)
  );

  nt_desc_check u_desc (
    .sel_i (sel_q),
    .hi_i  (mem_rdata_i),
    .flt_o (desc_flt)
  );

  nt_eip_check #(.EIP_W(EIP_W)) u_eip (
    .eip_i   (new_eip_i),
    .limit_i (new_cs_limit_i),
    .flt_o   (eip_flt)
  );

  always_comb begin
    gp_flt     = '0;
    gp_flt.hit = 1'b1;
    gp_flt.vec = VEC_GP;
  end

  assign desc_addr = gdt_base_i + {{PAD_W{1'b0}}, sel_q[SEL_W-1:3], 3'b000};

  always_comb begin
    unique case (state_q)
      ST_LINK: mem_addr_o = tr_base_i;
      ST_DLO:  mem_addr_o = desc_addr;
      ST_DHI:  mem_addr_o = desc_addr + ADDR_W'(4);
      default: mem_addr_o = '0;
    endcase
  end

  assign mem_req_o     = (state_q == ST_LINK) || (state_q == ST_DLO) || (state_q == ST_DHI);
  assign switch_req_o  = (state_q == ST_SWITCH);
  assign switch_sel_o  = sel_q;
  assign switch_desc_o = {dhi_q, dlo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      dlo_q     <= '0;
      dhi_q     <= '0;
      done_q    <= 1'b0;
      int_err_q <= 1'b0;
      fault_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          fault_q   <= '0;
          int_err_q <= 1'b0;
          if (long_mode_i) begin
            fault_q <= gp_flt;
            done_q  <= 1'b1;
          end else if (!tr_valid_i || v86_i) begin
            int_err_q <= 1'b1;
            done_q    <= 1'b1;
          end else begin
            state_q <= ST_LINK;
          end
        end
        ST_LINK: if (mem_ack_i) begin
          sel_q <= mem_rdata_i[SEL_W-1:0];
          if (link_flt.hit) begin
            fault_q <= link_flt;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_DLO;
          end
        end
        ST_DLO: if (mem_ack_i) begin
          dlo_q   <= mem_rdata_i;
          state_q <= ST_DHI;
        end
        ST_DHI: if (mem_ack_i) begin
          dhi_q <= mem_rdata_i;
          if (desc_flt.hit) begin
            fault_q <= desc_flt;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_SWITCH;
          end
        end
        ST_SWITCH: if (switch_done_i) begin
          fault_q <= eip_flt;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = done_q;
  assign fault_o     = fault_q.hit;
  assign fault_vec_o = fault_q.vec;
  assign fault_err_o = fault_q.err;
  assign int_err_o   = int_err_q;
endmodule

// File: rtl/nt_return_link_chk_sva.sv
`timescale 1ns/1ps
module nt_return_link_chk_sva
  import nt_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              switch_req_o,
  input logic              switch_done_i,
  input logic [15:0]       switch_sel_o,
  input logic [63:0]       switch_desc_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [7:0]        fault_vec_o,
  input logic [15:0]       fault_err_o,
  input logic              int_err_o
);
  // R1
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  // R7
  switch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    switch_req_o && !switch_done_i |=> switch_req_o && $stable(switch_sel_o) && $stable(switch_desc_o));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  one_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fault_o && int_err_o));

  // R11
  port_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && switch_req_o));

  // R2
  err_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_err_o[1:0] == 2'b00);

  // R8
  gp_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && fault_vec_o == VEC_GP |-> fault_err_o == 16'h0000);

  // R6
  vec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_vec_o == VEC_TS || fault_vec_o == VEC_NP || fault_vec_o == VEC_GP);

  // R12
  idle_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o && !switch_req_o);
endmodule

bind nt_return_link_chk nt_return_link_chk_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_req_o     (mem_req_o),
  .mem_ack_i     (mem_ack_i),
  .mem_addr_o    (mem_addr_o),
  .switch_req_o  (switch_req_o),
  .switch_done_i (switch_done_i),
  .switch_sel_o  (switch_sel_o),
  .switch_desc_o (switch_desc_o),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .fault_vec_o   (fault_vec_o),
  .fault_err_o   (fault_err_o),
  .int_err_o     (int_err_o)
);

// File: tb/nt_return_link_chk_tb.sv
`timescale 1ns/1ps
module nt_return_link_chk_tb;
  localparam logic [31:0] TR_BASE  = 32'h0000_8000;
  localparam logic [31:0] GDT_BASE = 32'h0000_1000;
  localparam logic [31:0] DLO_WORD = 32'h1234_0067;
  localparam int NV = 16;

  typedef struct packed {
    logic        lm, vm, trv;
    logic [15:0] sel, lim;
    logic [3:0]  typ;
    logic        s, p;
    logic [31:0] eip, csl;
    logic        x_ierr, x_flt;
    logic [7:0]  x_vec;
    logic [15:0] x_err;
    logic [1:0]  x_reads;
    logic        x_sw;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b1,16'h0028,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b0,8'd0,16'h0000,2'd3,1'b1},
    '{1'b0,1'b0,1'b1,16'h0033,16'h00FF,4'd3 ,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b0,8'd0,16'h0000,2'd3,1'b1},
    '{1'b0,1'b0,1'b1,16'h00F8,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b0,8'd0,16'h0000,2'd3,1'b1},
    '{1'b0,1'b0,1'b1,16'h002F,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b1,8'd10,16'h002C,2'd1,1'b0},
    '{1'b0,1'b0,1'b1,16'h0100,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b1,8'd10,16'h0100,2'd1,1'b0},
    '{1'b0,1'b0,1'b1,16'h0028,16'h00FF,4'd11,1'b1,1'b1,32'h100,32'hFFFF,1'b0,1'b1,8'd10,16'h0028,2'd3,1'b0},
    '{1'b0,1'b0,1'b1,16'h0028,16'h00FF,4'd9 ,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b1,8'd10,16'h0028,2'd3,1'b0},
    '{1'b0,1'b0,1'b1,16'h0028,16'h00FF,4'd1 ,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b1,8'd10,16'h0028,2'd3,1'b0},
    '{1'b0,1'b0,1'b1,16'h002A,16'h00FF,4'd11,1'b0,1'b0,32'h100,32'hFFFF,1'b0,1'b1,8'd11,16'h0028,2'd3,1'b0},
    '{1'b0,1'b0,1'b1,16'h0028,16'h00FF,4'd9 ,1'b0,1'b0,32'h100,32'hFFFF,1'b0,1'b1,8'd10,16'h0028,2'd3,1'b0},
    '{1'b0,1'b0,1'b1,16'h0028,16'h00FF,4'd11,1'b0,1'b1,32'h10000,32'hFFFF,1'b0,1'b1,8'd13,16'h0000,2'd3,1'b1},
    '{1'b0,1'b0,1'b1,16'h0028,16'h00FF,4'd11,1'b0,1'b1,32'hFFFF,32'hFFFF,1'b0,1'b0,8'd0,16'h0000,2'd3,1'b1},
    '{1'b1,1'b0,1'b1,16'h0028,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b1,8'd13,16'h0000,2'd0,1'b0},
    '{1'b1,1'b1,1'b0,16'h0028,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b0,1'b1,8'd13,16'h0000,2'd0,1'b0},
    '{1'b0,1'b0,1'b0,16'h0028,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b1,1'b0,8'd0,16'h0000,2'd0,1'b0},
    '{1'b0,1'b1,1'b1,16'h0028,16'h00FF,4'd11,1'b0,1'b1,32'h100,32'hFFFF,1'b1,1'b0,8'd0,16'h0000,2'd0,1'b0}
  };

  localparam string TAG [NV] = '{"R7","R5","R3","R2","R3","R4","R5","R5",
                                 "R6","R6","R8","R8","R10","R10","R9","R9"};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, long_mode = 1'b0, v86 = 1'b0, tr_valid = 1'b0;
  logic [15:0] gdt_limit = 16'h00FF;
  logic        mem_req, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        sw_req, sw_done = 1'b0;
  logic [15:0] sw_sel;
  logic [63:0] sw_desc;
  logic [31:0] new_eip = '0, new_cs_limit = '0;
  logic        done, fault, int_err;
  logic [7:0]  fault_vec;
  logic [15:0] fault_err;

  logic [15:0] cur_sel = '0;
  logic [31:0] cur_hi = '0;
  int rd_cnt = 0, sw_cnt = 0, done_cnt = 0;
  logic [15:0] cap_sel = '0;
  logic [63:0] cap_desc = '0;
  int checks = 0, errors = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  nt_return_link_chk u_dut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start),
    .long_mode_i (long_mode), .v86_i (v86), .tr_valid_i (tr_valid),
    .tr_base_i (TR_BASE), .gdt_base_i (GDT_BASE), .gdt_limit_i (gdt_limit),
    .mem_req_o (mem_req), .mem_addr_o (mem_addr), .mem_ack_i (mem_ack), .mem_rdata_i (mem_rdata),
    .switch_req_o (sw_req), .switch_sel_o (sw_sel), .switch_desc_o (sw_desc), .switch_done_i (sw_done),
    .new_eip_i (new_eip), .new_cs_limit_i (new_cs_limit),
    .done_o (done), .fault_o (fault), .fault_vec_o (fault_vec), .fault_err_o (fault_err),
    .int_err_o (int_err)
  );

  function automatic logic [31:0] lookup(input logic [31:0] a);
    logic [31:0] d;
    d = GDT_BASE + {16'h0, cur_sel[15:3], 3'b000};
    if (a == TR_BASE)        return {16'hABCD, cur_sel};
    else if (a == d)         return DLO_WORD;
    else if (a == d + 32'd4) return cur_hi;
    else                     return 32'hDEAD_BEEF;
  endfunction

  // memory and task-switch models: answer one cycle after a request
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      sw_done <= 1'b0;
    end else begin
      if (mem_req && mem_ack) rd_cnt <= rd_cnt + 1;
      if (sw_req && sw_done) sw_cnt <= sw_cnt + 1;
      if (sw_req) begin cap_sel <= sw_sel; cap_desc <= sw_desc; end
      if (done) done_cnt <= done_cnt + 1;
      mem_ack   <= mem_req && !mem_ack;
      mem_rdata <= lookup(mem_addr);
      sw_done   <= sw_req && !sw_done;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_done(input string req);
    for (int c = 0; c < 64; c++) begin
      if (done) break;
      @(negedge clk);
    end
    check(req, {63'h0, done}, 64'h1);
  endtask

  task automatic load_vec(input vec_t v);
    long_mode    = v.lm;
    v86          = v.vm;
    tr_valid     = v.trv;
    cur_sel      = v.sel;
    gdt_limit    = v.lim;
    cur_hi       = {16'h0, v.p, 2'b00, v.s, v.typ, 8'h00};
    new_eip      = v.eip;
    new_cs_limit = v.csl;
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int rd0, sw0;
    v = TBL[i];
    @(negedge clk);
    load_vec(v);
    rd0 = rd_cnt;
    sw0 = sw_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(TAG[i]);
    check(TAG[i], {63'h0, fault}, {63'h0, v.x_flt});
    check(TAG[i], {63'h0, int_err}, {63'h0, v.x_ierr});
    if (v.x_flt) begin
      check(TAG[i], {56'h0, fault_vec}, {56'h0, v.x_vec});
      check(TAG[i], {48'h0, fault_err}, {48'h0, v.x_err});
    end
    check(TAG[i], 64'(rd_cnt - rd0), {62'h0, v.x_reads});
    check(TAG[i], 64'(sw_cnt - sw0), {63'h0, v.x_sw});
    if (v.x_sw) begin
      check("R7", {48'h0, cap_sel}, {48'h0, v.sel});
      check("R7", cap_desc, {cur_hi, DLO_WORD});
    end
    @(negedge clk);
    check("R11", {63'h0, done}, 64'h0);
    check("R11", {63'h0, fault}, {63'h0, v.x_flt});
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL R11: watchdog expired, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int d0, rd0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", {59'h0, done, fault, int_err, mem_req, sw_req}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", {59'h0, done, fault, int_err, mem_req, sw_req}, 64'h0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11: start while busy is ignored
    @(negedge clk);
    load_vec(TBL[0]);
    d0 = done_cnt;
    rd0 = rd_cnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11");
    repeat (10) @(negedge clk);
    check("R11", 64'(done_cnt - d0), 64'd1);
    check("R11", 64'(rd_cnt - rd0), 64'd3);

    // R1: upper half of link word ignored, clean pass already uses 0xABCD there
    check("R1", {48'h0, cap_sel}, {48'h0, TBL[0].sel});

    // R12: reset mid-operation
    load_vec(TBL[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R12", {59'h0, done, fault, int_err, mem_req, sw_req}, 64'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R12", {62'h0, mem_req, sw_req}, 64'h0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule